// File: doc/BRIEF.md
# Dual Page-Size Translation Buffer

This block caches finished page translations so that an address needs no table walk when it is seen again. It holds two set-associative arrays side by side. One array holds 4 KB pages: 16 sets of 4 ways, indexed by linear bits 15:12 and tagged by bits 31:16. The other holds 4 MB pages: 2 sets of 4 ways, indexed by linear bit 22 and tagged by bits 31:23. A 32-bit linear address is presented on the lookup port. Both arrays are searched combinationally in the same cycle. The block returns a hit, the physical address made of the cached frame and the page offset, and the permission and attribute flags kept with that entry.

A page walker outside this block installs translations through the fill port. A page-size flag on that port selects the array. Within a set, a fill uses a free way if one exists, and otherwise the way named by a per-set round-robin pointer. A fill for an address that the target array already holds rewrites that entry in place. An ordinary flush discards every entry that is not marked global. A full flush discards every entry. Each flush takes one clock edge.

Top module: `dual_tlb`

## Requirements
- R1: After reset every entry of both arrays is invalid, so any lookup returns lk_hit=0, lk_conflict=0, lk_paddr=0 and lk_flags=0.
- R2: A small-page hit is reported in the same cycle as the lookup address. The set index is lk_addr[15:12] and the tag is lk_addr[31:16]. The result is lk_big=0 and lk_paddr = {stored 20-bit frame, lk_addr[11:0]}.
- R3: A large-page hit is reported in the same cycle. The set index is lk_addr[22] and the tag is lk_addr[31:23]. The result is lk_big=1 and lk_paddr = {fill_frame[19:10] as stored, lk_addr[21:0]}.
- R4: On a hit, lk_flags returns the flags stored by the fill with this encoding: bit0 writable, bit1 user, bit2 write-through, bit3 cache-disable, bit4 dirty, bit5 global. On a miss, lk_flags is 0.
- R5: A fill with fill_en=1 is written on the clock edge and is visible to lookups from the next cycle on. fill_big=0 selects the small array and fill_big=1 selects the large array.
- R6: A fill for an address not present in its set takes the lowest-numbered invalid way. If all ways are valid, it takes the way named by that set's round-robin pointer. The pointer starts at way 0 after reset and advances by one, wrapping, after each such eviction.
- R7: A fill for an address that already hits in the target array overwrites that entry's frame and flags. No other way is disturbed and the round-robin pointer does not move.
- R8: flush=1 invalidates, on one edge, every entry in both arrays whose global flag (bit5) is 0. Global entries stay valid.
- R9: flush_all=1 invalidates every entry in both arrays on one edge.
- R10: A fill presented in the same cycle as flush or flush_all is dropped.
- R11: If both arrays hit, lk_hit=1 and lk_conflict=1, and the small-page result is returned with lk_big=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_addr | input | 32 | Linear address to translate |
| lk_hit | output | 1 | A translation was found |
| lk_big | output | 1 | The returned translation is a large page |
| lk_paddr | output | 32 | Translated physical address |
| lk_flags | output | 6 | Flags of the returned entry |
| lk_conflict | output | 1 | Both arrays hit the address |
| fill_en | input | 1 | Install a translation |
| fill_big | input | 1 | 1 selects the large-page array |
| fill_addr | input | 32 | Linear address of the installed page |
| fill_frame | input | 20 | Physical frame bits 31:12 (large pages use the top 10 bits) |
| fill_flags | input | 6 | Flags to store, encoded as in R4 |
| flush | input | 1 | Invalidate non-global entries |
| flush_all | input | 1 | Invalidate all entries |

## Verification
Lookup results are combinational, so each lookup check drives the address on a falling edge and samples a few nanoseconds later, before the next rising edge. Fills and flushes act on the rising edge that follows their falling-edge drive, so their effect is first sampled at the next falling edge, one full cycle later. The bench sweeps every set and way of both arrays with arithmetic patterns, then replays eviction and in-place rewrite on one set. Each expected value is taken from the pointer sequence given in R6 and R7.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int LA_W      = 32;
    localparam int FRAME_W   = 20;
    localparam int FLAGS_W   = 6;
    localparam int SM_SHIFT  = 12;
    localparam int LG_SHIFT  = 22;

    typedef struct packed {
        logic glob;
        logic dirty;
        logic cdis;
        logic wthru;
        logic user;
        logic wr;
    } pte_flags_t;

    function automatic int idx_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int WAYS = 4,
    localparam int WAY_W = tlb_pkg::idx_bits(WAYS)
) (
    input  logic [WAYS-1:0]  valid_vec,
    input  logic [WAY_W-1:0] rr_ptr,
    output logic [WAY_W-1:0] pick,
    output logic             set_full
);
    logic             any_free;
    logic [WAY_W-1:0] free_way;

    always_comb begin
        any_free = 1'b0;
        free_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!valid_vec[w]) begin
                any_free = 1'b1;
                free_way = WAY_W'(w);
            end
        end
        set_full = !any_free;
        pick     = any_free ? free_way : rr_ptr;
    end
endmodule

// File: rtl/tlb_bank.sv
module tlb_bank
    import tlb_pkg::*;
#(
    parameter int SETS    = 16,
    parameter int WAYS    = 4,
    parameter int IDX_LSB = 12,
    localparam int IDX_W   = idx_bits(SETS),
    localparam int WAY_W   = idx_bits(WAYS),
    localparam int TAG_LSB = IDX_LSB + IDX_W,
    localparam int TAG_W   = LA_W - TAG_LSB,
    localparam int FRM_W   = LA_W - IDX_LSB
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LA_W-1:0]  lk_addr,
    output logic             lk_hit,
    output logic [FRM_W-1:0] lk_frame,
    output pte_flags_t       lk_flags,
    input  logic             wr_en,
    input  logic [LA_W-1:0]  wr_addr,
    input  logic [FRM_W-1:0] wr_frame,
    input  pte_flags_t       wr_flags,
    input  logic             clr_local,
    input  logic             clr_all
);
    logic [WAYS-1:0]  valid_q [SETS];
    logic [TAG_W-1:0] tag_q   [SETS][WAYS];
    logic [FRM_W-1:0] frame_q [SETS][WAYS];
    pte_flags_t       flags_q [SETS][WAYS];
    logic [WAY_W-1:0] ptr_q   [SETS];

    logic [IDX_W-1:0] lk_idx, wr_idx;
    logic [TAG_W-1:0] lk_tag, wr_tag;

    assign lk_idx = lk_addr[IDX_LSB +: IDX_W];
    assign lk_tag = lk_addr[LA_W-1:TAG_LSB];
    assign wr_idx = wr_addr[IDX_LSB +: IDX_W];
    assign wr_tag = wr_addr[LA_W-1:TAG_LSB];

    always_comb begin
        lk_hit   = 1'b0;
        lk_frame = '0;
        lk_flags = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (valid_q[lk_idx][w] && tag_q[lk_idx][w] == lk_tag) begin
                lk_hit   = 1'b1;
                lk_frame = frame_q[lk_idx][w];
                lk_flags = flags_q[lk_idx][w];
            end
        end
    end

    logic             wr_match;
    logic [WAY_W-1:0] wr_match_way;

    always_comb begin
        wr_match     = 1'b0;
        wr_match_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (valid_q[wr_idx][w] && tag_q[wr_idx][w] == wr_tag) begin
                wr_match     = 1'b1;
                wr_match_way = WAY_W'(w);
            end
        end
    end

    logic [WAY_W-1:0] vic_way, tgt_way, ptr_next;
    logic             vic_full;

    tlb_victim #(.WAYS(WAYS)) u_victim (
        .valid_vec (valid_q[wr_idx]),
        .rr_ptr    (ptr_q[wr_idx]),
        .pick      (vic_way),
        .set_full  (vic_full)
    );

    assign tgt_way  = wr_match ? wr_match_way : vic_way;
    assign ptr_next = (ptr_q[wr_idx] == WAY_W'(WAYS - 1)) ? '0 : ptr_q[wr_idx] + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                ptr_q[s]   <= '0;
            end
        end else if (clr_all) begin
            for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
        end else if (clr_local) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    valid_q[s][w] <= valid_q[s][w] && flags_q[s][w].glob;
        end else if (wr_en) begin
            valid_q[wr_idx][tgt_way] <= 1'b1;
            tag_q[wr_idx][tgt_way]   <= wr_tag;
            frame_q[wr_idx][tgt_way] <= wr_frame;
            flags_q[wr_idx][tgt_way] <= wr_flags;
            if (!wr_match && vic_full) ptr_q[wr_idx] <= ptr_next;
        end
    end
endmodule

// File: rtl/dual_tlb.sv
module dual_tlb
    import tlb_pkg::*;
#(
    parameter int SM_SETS = 16,
    parameter int SM_WAYS = 4,
    parameter int LG_SETS = 2,
    parameter int LG_WAYS = 4,
    localparam int SM_FRM_W = LA_W - SM_SHIFT,
    localparam int LG_FRM_W = LA_W - LG_SHIFT
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [LA_W-1:0]    lk_addr,
    output logic               lk_hit,
    output logic               lk_big,
    output logic [LA_W-1:0]    lk_paddr,
    output logic [FLAGS_W-1:0] lk_flags,
    output logic               lk_conflict,
    input  logic               fill_en,
    input  logic               fill_big,
    input  logic [LA_W-1:0]    fill_addr,
    input  logic [FRAME_W-1:0] fill_frame,
    input  logic [FLAGS_W-1:0] fill_flags,
    input  logic               flush,
    input  logic               flush_all
);
    logic                sm_hit, lg_hit;
    logic [SM_FRM_W-1:0] sm_frame;
    logic [LG_FRM_W-1:0] lg_frame;
    pte_flags_t          sm_flags, lg_flags;
    logic                fill_ok;

    assign fill_ok = fill_en && !flush && !flush_all;

    tlb_bank #(.SETS(SM_SETS), .WAYS(SM_WAYS), .IDX_LSB(SM_SHIFT)) u_small (
        .clk       (clk),
        .rst       (rst),
        .lk_addr   (lk_addr),
        .lk_hit    (sm_hit),
        .lk_frame  (sm_frame),
        .lk_flags  (sm_flags),
        .wr_en     (fill_ok && !fill_big),
        .wr_addr   (fill_addr),
        .wr_frame  (fill_frame[FRAME_W-1 -: SM_FRM_W]),
        .wr_flags  (pte_flags_t'(fill_flags)),
        .clr_local (flush),
        .clr_all   (flush_all)
    );

    tlb_bank #(.SETS(LG_SETS), .WAYS(LG_WAYS), .IDX_LSB(LG_SHIFT)) u_large (
        .clk       (clk),
        .rst       (rst),
        .lk_addr   (lk_addr),
        .lk_hit    (lg_hit),
        .lk_frame  (lg_frame),
        .lk_flags  (lg_flags),
        .wr_en     (fill_ok && fill_big),
        .wr_addr   (fill_addr),
        .wr_frame  (fill_frame[FRAME_W-1 -: LG_FRM_W]),
        .wr_flags  (pte_flags_t'(fill_flags)),
        .clr_local (flush),
        .clr_all   (flush_all)
    );

    always_comb begin
        lk_hit      = sm_hit || lg_hit;
        lk_conflict = sm_hit && lg_hit;
        lk_big      = lg_hit && !sm_hit;
        if (sm_hit) begin
            lk_paddr = {sm_frame, lk_addr[SM_SHIFT-1:0]};
            lk_flags = sm_flags;
        end else if (lg_hit) begin
            lk_paddr = {lg_frame, lk_addr[LG_SHIFT-1:0]};
            lk_flags = lg_flags;
        end else begin
            lk_paddr = '0;
            lk_flags = '0;
        end
    end
endmodule

// File: rtl/tlb_checker.sv
module tlb_checker (
    input logic        clk,
    input logic        rst,
    input logic [31:0] lk_addr,
    input logic        lk_hit,
    input logic        lk_big,
    input logic [31:0] lk_paddr,
    input logic [5:0]  lk_flags,
    input logic        lk_conflict,
    input logic        fill_en,
    input logic [31:0] fill_addr,
    input logic        flush,
    input logic        flush_all
);
    p_conflict_hit_r11: assert property (@(posedge clk) disable iff (rst)
        lk_conflict |-> (lk_hit && !lk_big));

    p_big_hit_r3: assert property (@(posedge clk) disable iff (rst)
        lk_big |-> lk_hit);

    p_small_offset_r2: assert property (@(posedge clk) disable iff (rst)
        (lk_hit && !lk_big) |-> (lk_paddr[11:0] == lk_addr[11:0]));

    p_large_offset_r3: assert property (@(posedge clk) disable iff (rst)
        lk_big |-> (lk_paddr[21:0] == lk_addr[21:0]));

    p_fullflush_r9: assert property (@(posedge clk) disable iff (rst)
        flush_all |=> !lk_hit);

    p_flush_global_r8: assert property (@(posedge clk) disable iff (rst)
        (flush && !flush_all) |=> (!lk_hit || lk_flags[5]));

    p_fill_visible_r5: assert property (@(posedge clk) disable iff (rst)
        ($past(fill_en && !flush && !flush_all && !rst) && lk_addr == $past(fill_addr))
        |-> lk_hit);

    p_miss_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        !lk_hit |-> (lk_flags == 6'd0 && lk_paddr == 32'd0 && !lk_conflict));
endmodule

bind dual_tlb tlb_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .lk_addr     (lk_addr),
    .lk_hit      (lk_hit),
    .lk_big      (lk_big),
    .lk_paddr    (lk_paddr),
    .lk_flags    (lk_flags),
    .lk_conflict (lk_conflict),
    .fill_en     (fill_en),
    .fill_addr   (fill_addr),
    .flush       (flush),
    .flush_all   (flush_all)
);

// File: tb/dual_tlb_bench.sv
module dual_tlb_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] lk_addr = '0;
    logic        lk_hit, lk_big, lk_conflict;
    logic [31:0] lk_paddr;
    logic [5:0]  lk_flags;
    logic        fill_en = 1'b0, fill_big = 1'b0;
    logic [31:0] fill_addr = '0;
    logic [19:0] fill_frame = '0;
    logic [5:0]  fill_flags = '0;
    logic        flush = 1'b0, flush_all = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    dual_tlb u_dual_tlb (
        .clk(clk), .rst(rst), .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_big(lk_big),
        .lk_paddr(lk_paddr), .lk_flags(lk_flags), .lk_conflict(lk_conflict),
        .fill_en(fill_en), .fill_big(fill_big), .fill_addr(fill_addr),
        .fill_frame(fill_frame), .fill_flags(fill_flags),
        .flush(flush), .flush_all(flush_all)
    );

    function automatic logic [31:0] sm_addr(int s, int w);
        logic [15:0] tag = 16'((w + 1) * 16'h0101 + s);
        return {tag, 4'(s), 12'h3A7 + 12'(w * 16)};
    endfunction
    function automatic logic [19:0] sm_frame(int s, int w);
        return {4'(w), 4'(s), 12'hA5C};
    endfunction
    function automatic logic [5:0] sm_flags(int s, int w);
        return {1'((w + s) & 1), 5'((s * 3 + w) & 31)};
    endfunction
    function automatic logic [31:0] lg_addr(int b, int w);
        logic [8:0] tag = 9'((w + 1) * 9'h021 + b);
        return {tag, 1'(b), 22'h2B_1C3D + 22'(w * 4096)};
    endfunction
    function automatic logic [19:0] lg_frame(int b, int w);
        return {3'(w), 1'(b), 6'h2D, 10'h000};
    endfunction
    function automatic logic [5:0] lg_flags(int b, int w);
        return {1'(w & 1), 5'((w * 5 + b) & 31)};
    endfunction

    task automatic do_fill(input logic big, input logic [31:0] a, input logic [19:0] f,
                           input logic [5:0] fl, input logic fl_one, input logic fl_all);
        @(negedge clk);
        fill_en = 1'b1; fill_big = big; fill_addr = a; fill_frame = f; fill_flags = fl;
        flush = fl_one; flush_all = fl_all;
        @(negedge clk);
        fill_en = 1'b0; flush = 1'b0; flush_all = 1'b0;
    endtask

    task automatic do_flush(input logic fl_all);
        @(negedge clk);
        flush = !fl_all; flush_all = fl_all;
        @(negedge clk);
        flush = 1'b0; flush_all = 1'b0;
    endtask

    task automatic look(input logic [31:0] a, input logic eh, input logic eb,
                        input logic [31:0] ep, input logic [5:0] ef, input logic ec,
                        input string req);
        @(negedge clk);
        lk_addr = a;
        #3;
        checks++;
        if (lk_hit !== eh || lk_big !== eb || lk_paddr !== ep || lk_flags !== ef ||
            lk_conflict !== ec) begin
            errors++;
            $display("FAIL %s addr=%h actual hit=%b big=%b pa=%h fl=%h cf=%b expected hit=%b big=%b pa=%h fl=%h cf=%b",
                     req, a, lk_hit, lk_big, lk_paddr, lk_flags, lk_conflict,
                     eh, eb, ep, ef, ec);
        end
    endtask

    task automatic look_sm(int s, int w, logic eh, string req);
        logic [31:0] a = sm_addr(s, w);
        if (eh) look(a, 1, 0, {sm_frame(s, w), a[11:0]}, sm_flags(s, w), 0, req);
        else    look(a, 0, 0, 32'd0, 6'd0, 0, req);
    endtask

    task automatic look_lg(int b, int w, logic eh, string req);
        logic [31:0] a = lg_addr(b, w);
        if (eh) look(a, 1, 1, {lg_frame(b, w)[19:10], a[21:0]}, lg_flags(b, w), 0, req);
        else    look(a, 0, 0, 32'd0, 6'd0, 0, req);
    endtask

    function automatic logic [31:0] rp_addr(int k);
        return {16'h0700 + 16'(k), 4'd3, 12'h111};
    endfunction

    task automatic look_rp(int k, logic eh, logic [19:0] fr, string req);
        if (eh) look(rp_addr(k), 1, 0, {fr, 12'h111}, 6'h01, 0, req);
        else    look(rp_addr(k), 0, 0, 32'd0, 6'd0, 0, req);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: empty after reset
        look(32'h0000_0000, 0, 0, 0, 0, 0, "R1");
        look(sm_addr(5, 2), 0, 0, 0, 0, 0, "R1");
        look(lg_addr(1, 3), 0, 0, 0, 0, 0, "R1");

        // R2 R4 R5 R6: fill every way of every small set, then read all back
        for (int s = 0; s < 16; s++)
            for (int w = 0; w < 4; w++)
                do_fill(0, sm_addr(s, w), sm_frame(s, w), sm_flags(s, w), 0, 0);
        for (int s = 0; s < 16; s++)
            for (int w = 0; w < 4; w++)
                look_sm(s, w, 1, "R2_R4_R6");

        // R3 R5: large array sweep
        for (int b = 0; b < 2; b++)
            for (int w = 0; w < 4; w++)
                do_fill(1, lg_addr(b, w), lg_frame(b, w), lg_flags(b, w), 0, 0);
        for (int b = 0; b < 2; b++)
            for (int w = 0; w < 4; w++)
                look_lg(b, w, 1, "R3_R5");
        // small entries untouched by large fills
        look_sm(9, 1, 1, "R5");

        // R8: ordinary flush keeps only global entries
        do_flush(0);
        for (int s = 0; s < 16; s++)
            for (int w = 0; w < 4; w++)
                look_sm(s, w, ((w + s) & 1) == 1, "R8");
        for (int b = 0; b < 2; b++)
            for (int w = 0; w < 4; w++)
                look_lg(b, w, (w & 1) == 1, "R8");

        // R9: full flush empties everything
        do_flush(1);
        for (int s = 0; s < 16; s++)
            for (int w = 0; w < 4; w++)
                look_sm(s, w, 0, "R9");
        for (int b = 0; b < 2; b++)
            for (int w = 0; w < 4; w++)
                look_lg(b, w, 0, "R9");

        // R6: replacement order on set 3
        for (int k = 0; k < 4; k++) do_fill(0, rp_addr(k), 20'h30000 + 20'(k), 6'h01, 0, 0);
        do_fill(0, rp_addr(4), 20'h30004, 6'h01, 0, 0);
        look_rp(0, 0, 0, "R6");
        for (int k = 1; k < 5; k++) look_rp(k, 1, 20'h30000 + 20'(k), "R6");
        do_fill(0, rp_addr(5), 20'h30005, 6'h01, 0, 0);
        look_rp(1, 0, 0, "R6");
        look_rp(5, 1, 20'h30005, "R6");

        // R7: rewrite in place, pointer unchanged
        do_fill(0, rp_addr(2), 20'h4BEEF, 6'h01, 0, 0);
        look_rp(2, 1, 20'h4BEEF, "R7");
        for (int k = 3; k < 6; k++) look_rp(k, 1, 20'h30000 + 20'(k), "R7");
        do_fill(0, rp_addr(6), 20'h30006, 6'h01, 0, 0);
        look_rp(2, 0, 0, "R7");
        for (int k = 3; k < 7; k++) look_rp(k, 1, 20'h30000 + 20'(k), "R7");

        // R11: small and large both cover the same address
        do_fill(0, 32'h0040_1234, 20'h11111, 6'h03, 0, 0);
        do_fill(1, 32'h0040_1234, 20'hAA800, 6'h0C, 0, 0);
        look(32'h0040_1234, 1, 0, 32'h1111_1234, 6'h03, 1, "R11");
        look(32'h0050_0000, 1, 1, {10'h2AA, 22'h10_0000}, 6'h0C, 0, "R11");

        // R10: fill dropped when a flush arrives in the same cycle
        do_fill(0, 32'h1234_5678, 20'h77777, 6'h21, 1, 0);
        look(32'h1234_5678, 0, 0, 0, 0, 0, "R10");
        do_fill(1, 32'h9AC0_0000, 20'h55400, 6'h21, 0, 1);
        look(32'h9AC0_0000, 0, 0, 0, 0, 0, "R10");
        look(32'h0040_1234, 0, 0, 0, 0, 0, "R10");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule